// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a byte-wide cache that sits between a processor request port and a line-wide port to the next memory level. Its geometry is set by three parameters: the number of sets is 2^SET_BITS, the number of ways is 2^WAY_BITS and the line length is 2^OFF_BITS bytes. Setting WAY_BITS to 0 gives a direct-mapped cache. Setting SET_BITS to 0 gives a fully associative cache. Each request address is split into a byte offset, a set index and a tag. All ways of the selected set are compared at once, and a hit is qualified by each way's valid bit.

Write hits stay in the cache and mark the line dirty. A miss allocates a line for both reads and writes. The way to replace is the lowest-numbered invalid way if one exists; otherwise it is the least recently used way. A dirty victim is written out whole before the new line is requested.

Both sides use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the processor must hold its request until it is taken. The response is a single-cycle `rsp_valid` pulse and cannot be back-pressured. On the memory side, `mem_wr_valid` and `mem_rd_valid` stay high with their payload unchanged until the matching ready is seen at a clock edge. The refill returns as a single-cycle `mem_rsp_valid` beat, which the controller always accepts while it is waiting for one.

Top module: `sawb_cache`

## Requirements
- R1: Address bits [OFF_BITS-1:0] select the byte, the next SET_BITS bits select the set, and the remaining upper bits are the tag. Every memory-side address is line aligned: its low OFF_BITS bits are zero. A refill uses the request's tag and set. A writeback uses the victim's stored tag and the current set.
- R2: A request hits only when a valid way of its set holds a matching tag. A hit raises `rsp_valid` in the cycle directly after the request is accepted, and it causes no memory-side transfer.
- R3: For a read, `rsp_rdata` is the byte at the addressed offset of the line. On the memory data buses, byte i of a line occupies bits [8i+7:8i]. `rsp_rdata` carries no defined value for writes.
- R4: A write hit changes only the addressed byte of the cached line and marks the line dirty. It causes no memory-side transfer.
- R5: On a miss, `req_ready` stays low from acceptance until the response. The response comes only after the refill line has arrived.
- R6: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the least recently used way. Both hits and refills count as uses.
- R7: A dirty victim is written back with its stored data before the refill request is issued. A clean or invalid victim causes no writeback.
- R8: A write miss first refills the line, then merges the write byte at its offset. The line is left dirty.
- R9: Reset clears every valid and dirty bit. After reset, `req_ready` is high and `rsp_valid`, `mem_wr_valid` and `mem_rd_valid` are low.
- R10: A memory-side valid stays high with a stable address and data until its ready is seen. A writeback and a refill request are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller takes a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_wr_valid | output | 1 | Writeback line present |
| mem_wr_ready | input | 1 | Memory takes the writeback |
| mem_wr_addr | output | ADDR_W | Line-aligned writeback address |
| mem_wr_data | output | 8*2^OFF_BITS | Writeback line |
| mem_rd_valid | output | 1 | Refill request present |
| mem_rd_ready | input | 1 | Memory takes the refill request |
| mem_rd_addr | output | ADDR_W | Line-aligned refill address |
| mem_rsp_valid | input | 1 | Refill line present, one cycle |
| mem_rsp_data | input | 8*2^OFF_BITS | Refill line |

## Verification
The bench builds the cache with four sets, two ways, four-byte lines and an 8-bit address, which leaves a 4-bit tag. Sixteen tags therefore compete for two ways in each set. That makes it easy to reach invalid-first fills, LRU eviction of a clean line, and eviction of a dirty line whose written byte must come back from memory on a later refill. The memory model holds each ready low for two cycles, so the hold rules on the memory side are exercised, and a long mixed read/write stream checks the replacement order against an independent model.

// File: rtl/sawb_pkg.sv
package sawb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cache_state_e;
endpackage

// File: rtl/sawb_tag_match.sv
// Parallel tag comparison across all ways of one set, qualified by valid bits.
module sawb_tag_match #(
  parameter int WAYS   = 2,
  parameter int WIDX_W = 1,
  parameter int TAG_W  = 4
) (
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WIDX_W-1:0]     hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WIDX_W'(w);
    end
  end
endmodule

// File: rtl/sawb_victim_sel.sv
// Lowest-numbered invalid way wins; otherwise the LRU way.
module sawb_victim_sel #(
  parameter int WAYS   = 2,
  parameter int WIDX_W = 1
) (
  input  logic [WAYS-1:0]   way_valid,
  input  logic [WIDX_W-1:0] lru_way,
  output logic [WIDX_W-1:0] victim
);
  always_comb begin
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WIDX_W'(w);
    end
  end
endmodule

// File: rtl/sawb_lru.sv
// Per-set age ranks: age 0 is most recent, WAYS-1 is least recent.
module sawb_lru #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int SIDX_W = 2,
  parameter int WIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch_en,
  input  logic [SIDX_W-1:0] touch_set,
  input  logic [WIDX_W-1:0] touch_way,
  input  logic [SIDX_W-1:0] query_set,
  output logic [WIDX_W-1:0] lru_way
);
  logic [WIDX_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WIDX_W'(WAYS - 1 - w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WIDX_W'(w) == touch_way) begin
          age_q[touch_set][w] <= '0;
        end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[query_set][w] == WIDX_W'(WAYS - 1)) lru_way = WIDX_W'(w);
    end
  end
endmodule

// File: rtl/sawb_cache.sv
module sawb_cache #(
  parameter int ADDR_W   = 8,
  parameter int SET_BITS = 2,
  parameter int WAY_BITS = 1,
  parameter int OFF_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [7:0]                 req_wdata,
  output logic                       rsp_valid,
  output logic [7:0]                 rsp_rdata,
  output logic                       mem_wr_valid,
  input  logic                       mem_wr_ready,
  output logic [ADDR_W-1:0]          mem_wr_addr,
  output logic [(8<<OFF_BITS)-1:0]   mem_wr_data,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic                       mem_rsp_valid,
  input  logic [(8<<OFF_BITS)-1:0]   mem_rsp_data
);
  import sawb_pkg::*;

  localparam int SETS       = 1 << SET_BITS;
  localparam int WAYS       = 1 << WAY_BITS;
  localparam int LINE_BYTES = 1 << OFF_BITS;
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int TAG_W      = ADDR_W - SET_BITS - OFF_BITS;
  localparam int SIDX_W     = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int WIDX_W     = (WAY_BITS > 0) ? WAY_BITS : 1;
  localparam int OIDX_W     = (OFF_BITS > 0) ? OFF_BITS : 1;

  // Line storage
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  // Control state and the request held for the whole transaction
  cache_state_e      state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [WIDX_W-1:0] vic_q;

  logic [SIDX_W-1:0] cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [OIDX_W-1:0] cur_off;

  assign cur_set = SIDX_W'((addr_q >> OFF_BITS) & ADDR_W'(SETS - 1));
  assign cur_tag = TAG_W'(addr_q >> (OFF_BITS + SET_BITS));
  assign cur_off = OIDX_W'(addr_q & ADDR_W'(LINE_BYTES - 1));

  logic [WAYS*TAG_W-1:0] set_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[cur_set][w];
  end

  logic              hit;
  logic [WIDX_W-1:0] hit_way;
  logic [WIDX_W-1:0] lru_way;
  logic [WIDX_W-1:0] victim;
  logic              fill_take;
  logic              lookup_hit;
  logic              touch_en;
  logic [WIDX_W-1:0] touch_way;

  sawb_tag_match #(.WAYS(WAYS), .WIDX_W(WIDX_W), .TAG_W(TAG_W)) u_match (
    .way_tags (set_tags),
    .way_valid(valid_q[cur_set]),
    .look_tag (cur_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  sawb_lru #(.SETS(SETS), .WAYS(WAYS), .SIDX_W(SIDX_W), .WIDX_W(WIDX_W)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch_en (touch_en),
    .touch_set(cur_set),
    .touch_way(touch_way),
    .query_set(cur_set),
    .lru_way  (lru_way)
  );

  sawb_victim_sel #(.WAYS(WAYS), .WIDX_W(WIDX_W)) u_victim (
    .way_valid(valid_q[cur_set]),
    .lru_way  (lru_way),
    .victim   (victim)
  );

  assign lookup_hit = (state_q == ST_LOOKUP) && hit;
  assign fill_take  = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
  assign touch_en   = lookup_hit || fill_take;
  assign touch_way  = fill_take ? vic_q : hit_way;

  // Port outputs
  logic [LINE_W-1:0] hit_line;
  assign hit_line     = data_q[cur_set][hit_way];
  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = lookup_hit;
  assign rsp_rdata    = hit_line[8*cur_off +: 8];
  assign mem_wr_valid = (state_q == ST_WBACK);
  assign mem_wr_data  = data_q[cur_set][vic_q];
  assign mem_wr_addr  = (ADDR_W'(tag_q[cur_set][vic_q]) << (OFF_BITS + SET_BITS))
                      | (ADDR_W'(cur_set) << OFF_BITS);
  assign mem_rd_valid = (state_q == ST_FILL_REQ);
  assign mem_rd_addr  = addr_q & ~ADDR_W'(LINE_BYTES - 1);

  // Data and tag arrays (no reset; guarded by valid bits)
  always_ff @(posedge clk) begin
    if (lookup_hit && wr_q) begin
      data_q[cur_set][hit_way][8*cur_off +: 8] <= wdata_q;
    end
    if (fill_take) begin
      data_q[cur_set][vic_q] <= mem_rsp_data;
      tag_q[cur_set][vic_q]  <= cur_tag;
    end
  end

  // Sequencer, valid and dirty bits
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      vic_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (wr_q) dirty_q[cur_set][hit_way] <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            vic_q   <= victim;
            state_q <= (valid_q[cur_set][victim] && dirty_q[cur_set][victim])
                       ? ST_WBACK : ST_FILL_REQ;
          end
        end
        ST_WBACK: begin
          if (mem_wr_ready) state_q <= ST_FILL_REQ;
        end
        ST_FILL_REQ: begin
          if (mem_rd_ready) state_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (mem_rsp_valid) begin
            valid_q[cur_set][vic_q] <= 1'b1;
            dirty_q[cur_set][vic_q] <= 1'b0;
            state_q <= ST_LOOKUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sawb_cache_chk.sv
module sawb_cache_chk #(
  parameter int ADDR_W   = 8,
  parameter int OFF_BITS = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     mem_wr_valid,
  input logic                     mem_wr_ready,
  input logic [ADDR_W-1:0]        mem_wr_addr,
  input logic [(8<<OFF_BITS)-1:0] mem_wr_data,
  input logic                     mem_rd_valid,
  input logic                     mem_rd_ready,
  input logic [ADDR_W-1:0]        mem_rd_addr,
  input logic                     mem_rsp_valid
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_BITS) - 1);

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_valid && mem_rd_valid));

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid || mem_rd_valid) |-> !req_ready);

  // R2
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid)));

  // R1
  rd_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> ((mem_rd_addr & OFF_MASK) == '0));

  // R1
  wb_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ((mem_wr_addr & OFF_MASK) == '0));
endmodule

bind sawb_cache sawb_cache_chk #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sim_sawb_cache.sv
`timescale 1ns/1ps
module sim_sawb_cache;
  localparam int ADDR_W   = 8;
  localparam int SET_BITS = 2;
  localparam int WAY_BITS = 1;
  localparam int OFF_BITS = 2;
  localparam int SETS     = 1 << SET_BITS;
  localparam int WAYS     = 1 << WAY_BITS;
  localparam int LB       = 1 << OFF_BITS;
  localparam int LINE_W   = 8 * LB;
  localparam int MEM_SZ   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic mem_wr_valid, mem_rd_valid;
  logic mem_wr_ready = 1'b0, mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] mem_wr_addr, mem_rd_addr;
  logic [LINE_W-1:0] mem_wr_data;
  logic [LINE_W-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  sawb_cache #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS), .OFF_BITS(OFF_BITS)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Next-level memory model
  logic [7:0] mem [MEM_SZ];
  int wb_cnt, rd_cnt, wb_cyc, rd_cyc, wr_wait = 0, rd_wait = 0, rd_delay = -1;
  int wb_addr_log, rd_addr_log, first_wb_addr;
  logic [LINE_W-1:0] wb_data_log, first_wb_data;

  initial begin
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_wr_ready) mem_wr_ready = 1'b0;
      else if (mem_wr_valid) begin
        if (wr_wait == 0) begin
          first_wb_addr = int'(mem_wr_addr);
          first_wb_data = mem_wr_data;
        end
        if (wr_wait < 2) wr_wait++;
        else begin
          wr_wait = 0;
          check(mem_wr_data == first_wb_data && int'(mem_wr_addr) == first_wb_addr,
                "R10", "writeback payload held", longint'(mem_wr_data), longint'(first_wb_data));
          wb_cnt++;
          wb_cyc = cyc;
          wb_addr_log = int'(mem_wr_addr);
          wb_data_log = mem_wr_data;
          for (int i = 0; i < LB; i++) mem[int'(mem_wr_addr) + i] = mem_wr_data[8*i +: 8];
          mem_wr_ready = 1'b1;
        end
      end
      if (mem_rd_ready) begin
        mem_rd_ready = 1'b0;
        rd_delay = 3;
      end else if (mem_rd_valid && rd_delay < 0) begin
        if (rd_wait < 2) rd_wait++;
        else begin
          rd_wait = 0;
          rd_cnt++;
          rd_cyc = cyc;
          rd_addr_log = int'(mem_rd_addr);
          mem_rd_ready = 1'b1;
        end
      end
      if (rd_delay > 0) begin
        rd_delay--;
        if (rd_delay == 0) begin
          for (int i = 0; i < LB; i++) mem_rsp_data[8*i +: 8] = mem[rd_addr_log + i];
          mem_rsp_valid = 1'b1;
          rd_delay = -1;
        end
      end
    end
  end

  // Behavioural reference cache
  bit         ref_valid [SETS][WAYS];
  bit         ref_dirty [SETS][WAYS];
  int         ref_tag   [SETS][WAYS];
  logic [7:0] ref_data  [SETS][WAYS][LB];
  int         lru_q     [SETS][$];

  task automatic touch(input int s, input int w);
    for (int i = 0; i < lru_q[s].size(); i++) begin
      if (lru_q[s][i] == w) begin
        lru_q[s].delete(i);
        break;
      end
    end
    lru_q[s].push_back(w);
  endtask

  task automatic access(input bit wr, input int addr, input int wdata, input string why);
    int s, t, o, w, lat;
    bit hit, exp_wb, stall_bad;
    int exp_wb_addr;
    logic [LINE_W-1:0] exp_wb_data;
    s = (addr >> OFF_BITS) & (SETS - 1);
    t = addr >> (OFF_BITS + SET_BITS);
    o = addr & (LB - 1);
    hit = 0; w = 0;
    for (int i = 0; i < WAYS; i++) if (ref_valid[s][i] && ref_tag[s][i] == t) begin hit = 1; w = i; end
    if (!hit) begin
      w = -1;
      for (int i = 0; i < WAYS; i++) if (!ref_valid[s][i] && w < 0) w = i;
      if (w < 0) w = lru_q[s][0];
    end
    exp_wb = !hit && ref_valid[s][w] && ref_dirty[s][w];
    exp_wb_addr = (ref_tag[s][w] << (OFF_BITS + SET_BITS)) | (s << OFF_BITS);
    for (int i = 0; i < LB; i++) exp_wb_data[8*i +: 8] = ref_data[s][w][i];
    wb_cnt = 0; rd_cnt = 0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = 8'(wdata);
    lat = 0; stall_bad = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!rsp_valid && req_ready) stall_bad = 1;
    end while (!rsp_valid && lat < 100);

    if (!hit) begin
      for (int i = 0; i < LB; i++) ref_data[s][w][i] = mem[(t << (OFF_BITS + SET_BITS)) | (s << OFF_BITS) | i];
      ref_valid[s][w] = 1; ref_dirty[s][w] = 0; ref_tag[s][w] = t;
      touch(s, w);
    end
    if (wr) begin
      ref_data[s][w][o] = 8'(wdata);
      ref_dirty[s][w] = 1;
    end
    touch(s, w);

    if (hit) begin
      check(lat == 1, $sformatf("R2 %s", why), "hit latency", lat, 1);
      check(wb_cnt == 0 && rd_cnt == 0, wr ? "R4" : "R2", "memory traffic on hit",
            wb_cnt + rd_cnt, 0);
    end else begin
      check(lat > 1 && lat < 100, $sformatf("R5 %s", why), "miss latency", lat, 2);
      check(!stall_bad, "R5", "req_ready low during miss", stall_bad, 0);
      check(rd_cnt == 1, "R5", "refill count", rd_cnt, 1);
      check(rd_addr_log == (addr & ~(LB - 1)), "R1", "refill address", rd_addr_log, addr & ~(LB - 1));
      check(wb_cnt == (exp_wb ? 1 : 0), "R7", "writeback count", wb_cnt, exp_wb);
      if (exp_wb) begin
        check(wb_addr_log == exp_wb_addr, "R1", "writeback address", wb_addr_log, exp_wb_addr);
        check(wb_data_log == exp_wb_data, "R7", "writeback data", longint'(wb_data_log), longint'(exp_wb_data));
        check(wb_cyc < rd_cyc, "R7", "writeback before refill", wb_cyc, rd_cyc);
      end
    end
    if (!wr) check(rsp_rdata == ref_data[s][w][o], why, "read data", rsp_rdata, ref_data[s][w][o]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
      ref_valid[s][w] = 0; ref_dirty[s][w] = 0; ref_tag[s][w] = 0;
      lru_q[s].push_back(w);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0 && mem_wr_valid == 1'b0 && mem_rd_valid == 1'b0,
          "R9", "outputs idle after reset", {rsp_valid, mem_wr_valid, mem_rd_valid}, 0);

    access(0, 'h00, 0, "R9");     // first access after reset misses
    access(0, 'h01, 0, "R3");
    access(0, 'h03, 0, "R3");
    access(1, 'h02, 'hAA, "R4");  // write hit
    access(0, 'h02, 0, "R4");
    access(0, 'h01, 0, "R4");     // neighbour byte untouched
    access(0, 'h10, 0, "R6");     // invalid way 1 filled
    access(0, 'h00, 0, "R6");     // way 0 now most recent
    access(0, 'h20, 0, "R6");     // evicts clean way 1
    access(0, 'h11, 0, "R6");     // was evicted, misses, evicts dirty way 0
    access(0, 'h02, 0, "R7");     // dirty byte must come back from memory
    access(1, 'h45, 'h3C, "R8");  // write miss
    access(0, 'h45, 0, "R8");
    access(0, 'h44, 0, "R8");
    access(0, 'h55, 0, "R8");
    access(0, 'h65, 0, "R8");     // evicts dirty line holding 0x45
    access(0, 'h45, 0, "R8");

    seed = 12345;
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      access(((seed >> 20) % 5) < 2, (seed >> 8) & (MEM_SZ - 1), (seed >> 3) & 8'hFF, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule